// File: doc/BRIEF.md
# Dithered PWM Digital-to-Analog Generator

This block drives one PWM pin from an 8-bit free-running period counter. Its average duty cycle follows a target with far finer resolution than 8 bits. The target is an unsigned fixed-point number. Its upper `CNT_W` bits are whole duty steps of 1/256 of a period. Its lower `FRAC_W` bits are a fraction of one step.

The duty of each period is not fixed. At every counter wrap, the whole-step part of an error accumulator becomes the compare value for the period that starts. That part is then cleared, and the fraction is kept as residual error. The target is then added. Over many periods the rounding error is carried forward rather than lost, so the filtered output tracks the full-width target.

A new target is captured with a load strobe into a holding register. It only enters the accumulator at a wrap, so no period is ever disturbed mid-way. The asynchronous active-low reset is released through a two-stage synchronizer. A period-start pulse is provided for observation.

Top module: `pwm_dither_dac`

## Requirements
- R1: While reset is asserted, `pwm_o` is low and the counter, the accumulator, the active compare value and the target holding register are zero. So the whole first period after reset is low.
- R2: A period lasts exactly 2^CNT_W (256) clock cycles. `period_start_o` is high in exactly one cycle of each period: its first cycle, in which the counter reads zero.
- R3: Within a period whose active compare value is D, `pwm_o` is high for the first D cycles and low for the rest. D = 0 gives a low period and D = 255 gives 255 high cycles out of 256.
- R4: At each wrap, the compare value for the next period is accumulator bits [ACC_W-1:FRAC_W] (the upper byte). In the same event, the accumulator becomes its lower FRAC_W bits plus the target, with the target zero-extended.
- R5: The target `target_i` is ACC_W (32) bits wide. Bits [31:24] are whole duty steps and bits [23:0] are a fraction of one step (2^24 = one step). With a constant target V loaded before the first wrap and no saturation, the high cycles over periods 1..N after reset total floor((N-1)·V / 2^24).
- R6: A value presented with `target_load_i` high is captured at that clock edge. It is first used at the next wrap that occurs after the capture edge. The active compare value never changes except at a wrap, so a load in mid-period leaves that period's high-time unchanged.
- R7: When the residual plus the target exceeds 2^ACC_W − 1, the accumulator saturates to all ones instead of wrapping. With target 0xFFFF_FFFF the duty settles at 255 every period.
- R8: A target of zero keeps `pwm_o` low in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances every cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| target_i | input | CNT_W+FRAC_W (32) | Fixed-point duty target, whole steps above a fraction |
| target_load_i | input | 1 | Captures `target_i` into the holding register |
| pwm_o | output | 1 | PWM output, high while counter is below the active compare value |
| period_start_o | output | 1 | High in the first cycle of every period |

## Verification
The bench builds the block with its default widths: an 8-bit counter and a 24-bit fraction. This makes one period 256 cycles, so each period's high-time can be counted exactly. The short period lets the bench step tens of periods per scenario. That is enough to see a half-step target alternate between 0 and 1. It is also enough to compare a long-run total against the floor formula, to watch the duty saturate at 255, and to place a load in the middle of a period.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_FRAC_W = 24;
endpackage

// File: rtl/dac_period_counter.sv
module dac_period_counter #(
  parameter int unsigned CNT_W = pwm_dither_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign wrap_o  = (cnt_q == CNT_LAST);
  assign start_o = (cnt_q == '0);

  // R2
  wrap_then_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> start_o);
endmodule

// File: rtl/dac_err_accum.sv
module dac_err_accum #(
  parameter int unsigned CNT_W  = pwm_dither_pkg::DEF_CNT_W,
  parameter int unsigned FRAC_W = pwm_dither_pkg::DEF_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrap_i,
  input  logic [CNT_W+FRAC_W-1:0] tgt_i,
  input  logic                    load_i,
  output logic [CNT_W-1:0]        whole_o
);
  localparam int unsigned ACC_W = CNT_W + FRAC_W;

  logic [ACC_W-1:0] tgt_q, tgt_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    tgt_d = load_i ? tgt_i : tgt_q;
    sum   = {1'b0, {CNT_W{1'b0}}, acc_q[FRAC_W-1:0]} + {1'b0, tgt_q};
    acc_d = acc_q;
    if (wrap_i) begin
      if (sum[ACC_W]) acc_d = '1;
      else            acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      acc_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      acc_q <= acc_d;
    end
  end

  assign whole_o = acc_q[ACC_W-1:FRAC_W];

  // R4 R7
  acc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> (acc_q >= $past(tgt_q)));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(acc_q));
endmodule

// File: rtl/dac_duty_stage.sv
module dac_duty_stage #(
  parameter int unsigned CNT_W = pwm_dither_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] next_duty_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_q, duty_d;

  always_comb begin
    duty_d = wrap_i ? next_duty_i : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  assign pwm_o = (cnt_i < duty_q);

  // R6
  duty_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(duty_q));

  // R3
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_o);
endmodule

// File: rtl/pwm_dither_dac.sv
module pwm_dither_dac #(
  parameter int unsigned CNT_W  = pwm_dither_pkg::DEF_CNT_W,
  parameter int unsigned FRAC_W = pwm_dither_pkg::DEF_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W+FRAC_W-1:0] target_i,
  input  logic                    target_load_i,
  output logic                    pwm_o,
  output logic                    period_start_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] next_duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  dac_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cnt_o   (cnt),
    .wrap_o  (wrap),
    .start_o (period_start_o)
  );

  dac_err_accum #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wrap_i  (wrap),
    .tgt_i   (target_i),
    .load_i  (target_load_i),
    .whole_o (next_duty)
  );

  dac_duty_stage #(.CNT_W(CNT_W)) u_duty (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wrap_i      (wrap),
    .cnt_i       (cnt),
    .next_duty_i (next_duty),
    .pwm_o       (pwm_o)
  );

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    period_start_o |=> !period_start_o);
endmodule

// File: tb/pwm_dither_dac_bench.sv
module pwm_dither_dac_bench;
  localparam int PER = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] target;
  logic        load;
  logic        pwm;
  logic        pstart;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] m_acc;
  int m_duty;
  int hi_cnt;
  int st_cnt;

  always #2 clk = ~clk;

  pwm_dither_dac u_pwm_dither_dac (
    .clk            (clk),
    .rst_n          (rst_n),
    .target_i       (target),
    .target_load_i  (load),
    .pwm_o          (pwm),
    .period_start_o (pstart)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_wrap(input logic [31:0] v);
    logic [63:0] s;
    m_duty = int'(m_acc[31:24]);
    s = {40'd0, m_acc[23:0]} + {32'd0, v};
    m_acc = (s > 64'h0000_0000_FFFF_FFFF) ? 64'h0000_0000_FFFF_FFFF : s;
  endtask

  // reset, then load v during period 0
  task automatic start_with(input logic [31:0] v);
    rst_n = 1'b0; load = 1'b0; target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_acc = '0;
    target = v; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // measure one period; optionally load nv after half a period
  task automatic measure(input logic [31:0] v_at_wrap, input bit do_load,
                         input logic [31:0] nv);
    while (!pstart) @(negedge clk);
    model_wrap(v_at_wrap);
    hi_cnt = 0; st_cnt = 0;
    for (int i = 0; i < PER; i++) begin
      hi_cnt += int'(pwm);
      st_cnt += int'(pstart);
      if (do_load && i == PER/2) begin
        target = nv; load = 1'b1;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
    end
    load = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load = 1'b0; target = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 pwm low in reset", int'(pwm), 0);
    check("R1 counter zero in reset", int'(pstart), 1);
    start_with(32'h4000_0000);
    measure(32'h4000_0000, 1'b0, '0);
    check("R1 first period after reset low", hi_cnt, 0);
  endtask

  task automatic t_zero;
    start_with(32'h0);
    for (int p = 0; p < 4; p++) begin
      measure(32'h0, 1'b0, '0);
      check("R8 zero target", hi_cnt, 0);
      check("R2 one start per period", st_cnt, 1);
    end
  endtask

  task automatic t_whole;
    start_with(32'h4000_0000);
    measure(32'h4000_0000, 1'b0, '0);
    for (int p = 0; p < 3; p++) begin
      measure(32'h4000_0000, 1'b0, '0);
      check("R3 whole-step duty 64", hi_cnt, 64);
      check("R4 duty from upper byte", hi_cnt, m_duty);
    end
  endtask

  task automatic t_frac(input logic [31:0] v, input int n);
    longint total = 0;
    longint exp_total;
    start_with(v);
    for (int p = 0; p < n; p++) begin
      measure(v, 1'b0, '0);
      check("R4 per-period duty", hi_cnt, m_duty);
      total += hi_cnt;
    end
    exp_total = (longint'(n - 1) * longint'(v)) >>> 24;
    check("R5 total high cycles", int'(total), int'(exp_total));
  endtask

  task automatic t_half;
    start_with(32'h0080_0000);
    measure(32'h0080_0000, 1'b0, '0);
    measure(32'h0080_0000, 1'b0, '0);
    check("R5 half step period 2", hi_cnt, 0);
    measure(32'h0080_0000, 1'b0, '0);
    check("R5 half step period 3", hi_cnt, 1);
    measure(32'h0080_0000, 1'b0, '0);
    check("R5 half step period 4", hi_cnt, 0);
  endtask

  task automatic t_midload;
    start_with(32'h1000_0000);
    measure(32'h1000_0000, 1'b0, '0);
    measure(32'h1000_0000, 1'b0, '0);
    check("R3 duty 16 before load", hi_cnt, 16);
    measure(32'h1000_0000, 1'b1, 32'h3000_0000);
    check("R6 mid-period load leaves period", hi_cnt, 16);
    measure(32'h3000_0000, 1'b0, '0);
    check("R6 acc used old duty this period", hi_cnt, 16);
    measure(32'h3000_0000, 1'b0, '0);
    check("R6 new target after next wrap", hi_cnt, 48);
  endtask

  task automatic t_sat;
    start_with(32'hFFFF_FFFF);
    measure(32'hFFFF_FFFF, 1'b0, '0);
    for (int p = 0; p < 3; p++) begin
      measure(32'hFFFF_FFFF, 1'b0, '0);
      check("R7 saturated duty 255", hi_cnt, 255);
      check("R2 one start per period", st_cnt, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; target = '0;
    m_acc = '0; m_duty = 0;
    t_reset();
    t_zero();
    t_whole();
    t_half();
    t_frac(32'h7F55_5555, 12);
    t_frac(32'h0123_4567, 12);
    t_midload();
    t_sat();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule